// File: doc/BRIEF.md
# Key-Unlocked Register Write Guard

This unit sits on a register write bus made of a memory-map select, an address, a data word and a one-cycle write strobe. For every write it decides, in the same cycle, whether the strobe may go on to the register space behind it. A single write-enable bit governs protection. While the bit is set, every write passes. Once it is cleared, writes to whole protected memory maps (2, 3 and 4) and to a fixed set of protected addresses in maps 0, 1 and 10 are stopped, and a sticky violation flag records the attempt.

The write-enable bit lives in a lock-control register that the guard holds itself, at memory map 10, address 0x00F0 by default. This register is locked out of reset. Only an exact pair of key writes to it opens it: first 32'h53464352, then 32'h434F4E46. After that, a write to the control register sets write-enable from data bit 0. Any write to a different register during the key sequence, or while the register is open, relocks it at once. Writes to the control register are consumed by the guard and are never forwarded. Its contents can be read on a status output.

Top module: `reg_write_guard`

## Requirements
- R1: After reset the status output reads 32'h1: write-enable (bit 0) is 1, key-one-accepted (bit 1) is 0 and key-two-accepted (bit 2) is 0. The violation flag is 0.
- R2: While write-enable is 0, writes are blocked: wr_pass_o stays low and wr_block_o goes high in the write's own cycle. This applies to any address in maps 2, 3 and 4. In map 0 it applies to 0x3, 0x4, 0x8, 0x9, 0xC and 0xD. In map 1 it applies to 0x0, 0x1, 0x20 to 0x2D, 0x32, 0x33, 0x6F, 0x70, 0x74 to 0x77 and 0x200. In map 10 it applies to 0x81, 0x82, 0x88, 0x89, 0x8C, 0x96, 0x100 to 0x102, 0x200 to 0x203, 0x220 to 0x23B and 0x23D.
- R3: While write-enable is 0, a write to any address outside the R2 set, other than the control register, raises wr_pass_o in its own cycle.
- R4: While the control register is locked, writes to it never change write-enable.
- R5: While locked, writing 32'h53464352 to the control register sets status bit 1 from the next cycle.
- R6: With status bit 1 set, writing 32'h434F4E46 to the control register sets status bit 2 and unlocks the register.
- R7: With status bit 1 set, writing any other value to the control register relocks it and clears bit 1.
- R8: While bit 1 is set, a write to any other register relocks the control register and clears bits 1 and 2. That write is judged against the write-enable value in force before it, and write-enable keeps that value.
- R9: While unlocked, a control-register write loads write-enable from data bit 0, and the register stays unlocked.
- R10: A control-register write never raises wr_pass_o.
- R11: A blocked write sets viol_o from the next cycle. It stays set until a cycle with viol_clr_i high and no blocked write. A blocked write wins over a clear in the same cycle.
- R12: While write-enable is 1, every write outside the control register raises wr_pass_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, one write per cycle |
| wr_mms_i | input | 4 | Memory-map select of the write |
| wr_addr_i | input | 16 | Register address of the write |
| wr_data_i | input | DATA_W | Write data |
| viol_clr_i | input | 1 | Clears the sticky violation flag |
| wr_pass_o | output | 1 | Forwarded write strobe |
| wr_block_o | output | 1 | The current write is blocked |
| ctrl_rdata_o | output | DATA_W | Control/status contents: bit 0 write-enable, bit 1 key one accepted, bit 2 key two accepted |
| viol_o | output | 1 | Sticky violation flag |

## Verification
The hardest state to reach is a relocking write that is itself checked against the protection in force before it. To get there, the bench must first open the register with both keys and clear write-enable. It then issues a protected write while the register is still open. The bench drives that full chain of writes and then sweeps every map against every address up to 0x3FF, comparing the pass strobe with a membership model written separately. It also covers both outcomes of a same-cycle block and clear.

// File: rtl/regguard_pkg.sv
package regguard_pkg;

    localparam int MMS_W  = 4;
    localparam int ADDR_W = 16;

    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_KEY1   = 2'd1,
        LK_OPEN   = 2'd2
    } lk_state_e;

    typedef struct packed {
        lk_state_e st;
        logic      we;
    } lk_regs_t;

    typedef struct packed {
        logic viol;
    } top_regs_t;

    // entry: {whole_map, mms, low address, high address}
    localparam int ENTRY_W    = 1 + MMS_W + 2 * ADDR_W;
    localparam int NUM_RANGES = 20;

    localparam logic [NUM_RANGES-1:0][ENTRY_W-1:0] PROT_TABLE = {
        {1'b1, 4'd2,  16'h0000, 16'h0000},
        {1'b1, 4'd3,  16'h0000, 16'h0000},
        {1'b1, 4'd4,  16'h0000, 16'h0000},
        {1'b0, 4'd0,  16'h0003, 16'h0004},
        {1'b0, 4'd0,  16'h0008, 16'h0009},
        {1'b0, 4'd0,  16'h000C, 16'h000D},
        {1'b0, 4'd1,  16'h0000, 16'h0001},
        {1'b0, 4'd1,  16'h0020, 16'h002D},
        {1'b0, 4'd1,  16'h0032, 16'h0033},
        {1'b0, 4'd1,  16'h006F, 16'h0070},
        {1'b0, 4'd1,  16'h0074, 16'h0077},
        {1'b0, 4'd1,  16'h0200, 16'h0200},
        {1'b0, 4'd10, 16'h0081, 16'h0082},
        {1'b0, 4'd10, 16'h0088, 16'h0089},
        {1'b0, 4'd10, 16'h008C, 16'h008C},
        {1'b0, 4'd10, 16'h0096, 16'h0096},
        {1'b0, 4'd10, 16'h0100, 16'h0102},
        {1'b0, 4'd10, 16'h0200, 16'h0203},
        {1'b0, 4'd10, 16'h0220, 16'h023B},
        {1'b0, 4'd10, 16'h023D, 16'h023D}
    };

endpackage

// File: rtl/regguard_prot_decode.sv
module regguard_prot_decode
    import regguard_pkg::*;
(
    input  logic [MMS_W-1:0]  mms_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);

    logic [NUM_RANGES-1:0] hit_vec;

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_range
        localparam logic              WHOLE = PROT_TABLE[i][ENTRY_W-1];
        localparam logic [MMS_W-1:0]  MAP   = PROT_TABLE[i][2*ADDR_W +: MMS_W];
        localparam logic [ADDR_W-1:0] LO    = PROT_TABLE[i][ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] HI    = PROT_TABLE[i][0 +: ADDR_W];
        localparam logic [ADDR_W-1:0] SPAN  = HI - LO;
        if (WHOLE) begin : g_whole
            assign hit_vec[i] = (mms_i == MAP);
        end else begin : g_span
            logic [ADDR_W-1:0] off;
            assign off        = addr_i - LO;
            assign hit_vec[i] = (mms_i == MAP) && (off <= SPAN);
        end
    end

    assign hit_o = |hit_vec;

    always_comb begin
        if (mms_i inside {4'd2, 4'd3, 4'd4}) begin
            assert_whole_map_R2: assert (hit_o);
        end
    end

endmodule

// File: rtl/regguard_lock_fsm.sv
module regguard_lock_fsm
    import regguard_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY_A  = 32'h53464352,
    parameter logic [DATA_W-1:0] KEY_B  = 32'h434F4E46
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic              is_ctrl_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              we_o,
    output logic              key1_o,
    output logic              key2_o
);

    lk_regs_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (wr_i) begin
            if (is_ctrl_i) begin
                case (lk_q.st)
                    LK_LOCKED: if (data_i == KEY_A) lk_d.st = LK_KEY1;
                    LK_KEY1:   lk_d.st = (data_i == KEY_B) ? LK_OPEN : LK_LOCKED;
                    LK_OPEN:   lk_d.we = data_i[0];
                    default:   lk_d.st = LK_LOCKED;
                endcase
            end else begin
                lk_d.st = LK_LOCKED;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lk_q <= '{st: LK_LOCKED, we: 1'b1};
        end else begin
            lk_q <= lk_d;
        end
    end

    assign we_o   = lk_q.we;
    assign key1_o = (lk_q.st == LK_KEY1) || (lk_q.st == LK_OPEN);
    assign key2_o = (lk_q.st == LK_OPEN);

    assert_we_only_when_open_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(lk_q.we) |-> $past(lk_q.st == LK_OPEN && wr_i && is_ctrl_i));

    assert_unlock_needs_keys_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lk_q.st == LK_OPEN) |-> $past(lk_q.st == LK_KEY1 && wr_i && is_ctrl_i && data_i == KEY_B));

    assert_stray_write_relocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i && !is_ctrl_i |=> lk_q.st == LK_LOCKED && !key1_o && !key2_o);

    assert_wrong_key_relocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_q.st == LK_KEY1 && wr_i && is_ctrl_i && data_i != KEY_B |=> lk_q.st == LK_LOCKED);

endmodule

// File: rtl/reg_write_guard.sv
module reg_write_guard
    import regguard_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter logic [MMS_W-1:0]  CTRL_MMS  = 4'd10,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h00F0,
    parameter logic [DATA_W-1:0] KEY_A     = 32'h53464352,
    parameter logic [DATA_W-1:0] KEY_B     = 32'h434F4E46
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [3:0]        wr_mms_i,
    input  logic [15:0]       wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              viol_clr_i,
    output logic              wr_pass_o,
    output logic              wr_block_o,
    output logic [DATA_W-1:0] ctrl_rdata_o,
    output logic              viol_o
);

    localparam int STAT_BITS = 3;
    localparam int PAD_W     = DATA_W - STAT_BITS;

    logic      is_ctrl;
    logic      prot_hit;
    logic      we;
    logic      key1;
    logic      key2;
    top_regs_t top_d, top_q;

    assign is_ctrl = (wr_mms_i == CTRL_MMS) && (wr_addr_i == CTRL_ADDR);

    regguard_prot_decode u_decode (
        .mms_i  (wr_mms_i),
        .addr_i (wr_addr_i),
        .hit_o  (prot_hit)
    );

    regguard_lock_fsm #(
        .DATA_W (DATA_W),
        .KEY_A  (KEY_A),
        .KEY_B  (KEY_B)
    ) u_lock (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_i),
        .is_ctrl_i (is_ctrl),
        .data_i    (wr_data_i),
        .we_o      (we),
        .key1_o    (key1),
        .key2_o    (key2)
    );

    always_comb begin
        top_d      = top_q;
        wr_block_o = wr_i && !is_ctrl && prot_hit && !we;
        wr_pass_o  = wr_i && !is_ctrl && !wr_block_o;
        if (viol_clr_i) top_d.viol = 1'b0;
        if (wr_block_o) top_d.viol = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            top_q <= '{viol: 1'b0};
        end else begin
            top_q <= top_d;
        end
    end

    assign viol_o       = top_q.viol;
    assign ctrl_rdata_o = {{PAD_W{1'b0}}, key2, key1, we};

    assert_protected_not_forwarded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i && prot_hit && !ctrl_rdata_o[0] |-> !wr_pass_o);

    assert_ctrl_never_forwarded_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i && is_ctrl |-> !wr_pass_o);

    assert_open_forwards_all_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i && !is_ctrl && ctrl_rdata_o[0] |-> wr_pass_o);

    assert_block_sets_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_block_o |=> viol_o);

    assert_flag_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_o && !viol_clr_i |=> viol_o);

    always_comb begin
        assert_key2_implies_key1_R6: assert (!rst_ni || !ctrl_rdata_o[2] || ctrl_rdata_o[1]);
    end

endmodule

// File: tb/reg_write_guard_bench.sv
module reg_write_guard_bench;

    localparam logic [3:0]  C_MMS  = 4'd10;
    localparam logic [15:0] C_ADDR = 16'h00F0;
    localparam logic [31:0] K1     = 32'h53464352;
    localparam logic [31:0] K2     = 32'h434F4E46;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  mms = '0;
    logic [15:0] addr = '0;
    logic [31:0] data = '0;
    logic        clr = 1'b0;
    logic        pass;
    logic        blk;
    logic [31:0] stat;
    logic        viol;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    reg_write_guard u_reg_write_guard (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_i         (wr),
        .wr_mms_i     (mms),
        .wr_addr_i    (addr),
        .wr_data_i    (data),
        .viol_clr_i   (clr),
        .wr_pass_o    (pass),
        .wr_block_o   (blk),
        .ctrl_rdata_o (stat),
        .viol_o       (viol)
    );

    function automatic logic prot_model(input logic [3:0] m, input logic [15:0] a);
        case (m)
            4'd2, 4'd3, 4'd4: return 1'b1;
            4'd0:  return a inside {16'h3, 16'h4, 16'h8, 16'h9, 16'hC, 16'hD};
            4'd1:  return a inside {16'h0, 16'h1, [16'h20:16'h2D], 16'h32, 16'h33,
                                    16'h6F, 16'h70, [16'h74:16'h77], 16'h200};
            4'd10: return a inside {16'h81, 16'h82, 16'h88, 16'h89, 16'h8C, 16'h96,
                                    [16'h100:16'h102], [16'h200:16'h203],
                                    [16'h220:16'h23B], 16'h23D};
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one write; pass sampled in the write's cycle, away from the edge
    task automatic bus_write(input logic [3:0] m, input logic [15:0] a, input logic [31:0] d,
                             input logic c, output logic p);
        @(negedge clk);
        wr = 1'b1; mms = m; addr = a; data = d; clr = c;
        #1 p = pass;
        @(posedge clk);
        #1 wr = 1'b0; clr = 1'b0;
    endtask

    task automatic idle_clear();
        @(negedge clk);
        clr = 1'b1;
        @(posedge clk);
        #1 clr = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic p;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();
        check("R1 reset status", stat, 32'h1);
        check("R1 reset violation", {31'b0, viol}, 32'h0);

        // R12: protection off, every non-control write passes
        for (int m = 0; m < 16; m++) begin
            for (int a = 0; a < 16'h280; a += 3) begin
                if (!(m == C_MMS && a == C_ADDR)) begin
                    bus_write(m[3:0], a[15:0], 32'hA5A5_0000 ^ a, 1'b0, p);
                    check("R12 pass while enabled", {31'b0, p}, 32'h1);
                end
            end
        end

        // R4/R10: locked control write changes nothing and is not forwarded
        bus_write(C_MMS, C_ADDR, 32'h0, 1'b0, p);
        check("R10 control write not forwarded", {31'b0, p}, 32'h0);
        settle();
        check("R4 locked write ignored", stat, 32'h1);

        // R5 then R7
        bus_write(C_MMS, C_ADDR, K1, 1'b0, p);
        settle();
        check("R5 first key accepted", stat, 32'h3);
        bus_write(C_MMS, C_ADDR, K1, 1'b0, p);
        settle();
        check("R7 wrong second key relocks", stat, 32'h1);

        // R8 stray write after first key
        bus_write(C_MMS, C_ADDR, K1, 1'b0, p);
        bus_write(4'd0, 16'h0000, 32'h1234, 1'b0, p);
        check("R8 stray write passes under old enable", {31'b0, p}, 32'h1);
        settle();
        check("R8 stray write after key1 relocks", stat, 32'h1);

        // R6 unlock, R9 write-enable updates
        bus_write(C_MMS, C_ADDR, K1, 1'b0, p);
        bus_write(C_MMS, C_ADDR, K2, 1'b0, p);
        settle();
        check("R6 unlocked status", stat, 32'h7);
        bus_write(C_MMS, C_ADDR, 32'hFFFF_FFFE, 1'b0, p);
        settle();
        check("R9 clear enable stays open", stat, 32'h6);
        bus_write(C_MMS, C_ADDR, 32'h1, 1'b0, p);
        settle();
        check("R9 set enable", stat, 32'h7);
        bus_write(C_MMS, C_ADDR, 32'h0, 1'b0, p);
        settle();
        check("R9 clear enable again", stat, 32'h6);

        // R8: relocking write judged with enable=0 in force
        bus_write(4'd2, 16'h0005, 32'hDEAD, 1'b0, p);
        check("R8 relocking protected write blocked", {31'b0, p}, 32'h0);
        settle();
        check("R8 relock keeps enable 0", stat, 32'h0);
        check("R11 violation set", {31'b0, viol}, 32'h1);

        // R11 clear
        idle_clear();
        settle();
        check("R11 violation cleared", {31'b0, viol}, 32'h0);

        // R2/R3: exhaustive sweep with protection active
        for (int m = 0; m < 16; m++) begin
            for (int a = 0; a < 16'h400; a++) begin
                if (!(m == C_MMS && a == C_ADDR)) begin
                    bus_write(m[3:0], a[15:0], 32'h0, 1'b0, p);
                    if (prot_model(m[3:0], a[15:0]))
                        check("R2 protected write blocked", {31'b0, p}, 32'h0);
                    else
                        check("R3 unprotected write passes", {31'b0, p}, 32'h1);
                end
            end
        end
        settle();
        check("R11 violation after sweep", {31'b0, viol}, 32'h1);

        // R2 wr_block_o in the write's cycle
        @(negedge clk);
        wr = 1'b1; mms = 4'd1; addr = 16'h0029; data = 32'h0;
        #1 check("R2 block strobe high", {31'b0, blk}, 32'h1);
        @(posedge clk);
        #1 wr = 1'b0;

        // R11: blocked write and clear in the same cycle, blocked wins
        bus_write(4'd3, 16'h0100, 32'h0, 1'b1, p);
        settle();
        check("R11 set wins over clear", {31'b0, viol}, 32'h1);
        idle_clear();
        bus_write(4'd0, 16'h0005, 32'h0, 1'b1, p);
        settle();
        check("R11 clear with unblocked write", {31'b0, viol}, 32'h0);

        // R4 locked with enable 0
        bus_write(C_MMS, C_ADDR, 32'h1, 1'b0, p);
        settle();
        check("R4 locked cannot re-enable", stat, 32'h0);

        // reopen, re-enable, protected write passes and relocks
        bus_write(C_MMS, C_ADDR, K1, 1'b0, p);
        bus_write(C_MMS, C_ADDR, K2, 1'b0, p);
        bus_write(C_MMS, C_ADDR, 32'h1, 1'b0, p);
        settle();
        check("R9 re-enable", stat, 32'h7);
        bus_write(4'd3, 16'h0040, 32'h0, 1'b0, p);
        check("R12 protected write passes when enabled", {31'b0, p}, 32'h1);
        settle();
        check("R8 relock after unlocked stray", stat, 32'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule